// File: doc/BRIEF.md
# NAND Flash Device Front End

This block is a synthesizable stand-in for the device side of a small-page, byte-wide NAND flash. A host drives commands, addresses and data over one shared 8-bit bus. Separate strobes say what each byte is: a command enable, an address enable, a write strobe, a read strobe, an active-low select and an active-low lock input. Every strobe is sampled on the system clock. A byte is taken on the clock where the write strobe is first seen high after being low. A read step happens on the clock where the read strobe is first seen low after being high.

Inside, a page buffer holds one whole page of 528 bytes by default (512 main and 16 spare). A column pointer steps through the buffer on every data write and every data read. A small behavioural array of whole pages stands in for the cell storage. Pages are grouped into erase blocks of 32 pages. Page reads, programs and block erases each keep the `ready` output low for a parameterized number of clock cycles. The defaults follow the ratio 15 : 200 : 2000.

Command codes: 00h reads a page, 80h opens a data load, 10h programs the loaded page, 60h opens an erase, D0h confirms the erase, 70h selects the status byte and FFh resets. A read or a load takes one column byte and then three row bytes. An erase takes only the three row bytes. The low bits of the first row byte pick the array page.

Top module: `nand_dev_top`

## Requirements
- R1: A bus cycle counts only while `selN` is low. A data byte written with `selN` high neither enters the page buffer nor moves the column pointer.
- R2: 00h followed by four address cycles (the column, then three row bytes) starts a page read. At its end the page buffer holds the addressed array page and the column pointer holds the given column.
- R3: 80h fills the whole page buffer with FFh. After the four address cycles, each data cycle (`cmdEn` and `addrEn` both low) writes `busIn` at the column pointer and advances it by one.
- R4: Each read step loads the buffer byte at the column pointer into the output register. The byte is on `busOut` from the clock after the one where `rdStrobeN` is first sampled low. The pointer then advances by one and wraps from the last byte of the page to 0.
- R5: `busOe` is high only while `selN` and `rdStrobeN` are both low. While it is low, `busOut` is 00h.
- R6: `ready` is high after reset. It falls on the clock that takes the last byte of a read address, a 10h or a D0h, and it stays low for exactly READ_BUSY, PROG_BUSY or ERASE_BUSY cycles.
- R7: A program (10h after a complete load) writes the whole page buffer into the addressed array page and leaves every other page unchanged.
- R8: An erase (60h, three row bytes, D0h) sets every byte of every page in the addressed block to FFh. Pages of other blocks are unchanged.
- R9: If `lockN` is low at 10h or at D0h, or when the busy time of a program or erase runs out, the array is not changed and the fail bit is set. A 10h or D0h refused this way does not lower `ready`.
- R10: After 70h each read step returns the status byte until the next 00h, 80h, 60h or FFh. Status bit 7 is `lockN`, bit 6 is ready, bit 0 is the fail bit and bits 5 to 1 are 0.
- R11: Raising `selN` while busy neither ends nor cancels the operation.
- R12: FFh is accepted at any time. It ends any busy period at once, with `ready` high on the next cycle, changes nothing in the array, and clears the fail bit and the status selection.
- R13: While busy, every command other than 70h and FFh is ignored, and so are address and data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | synchronous reset, active low |
| selN | input | 1 | device select, active low |
| cmdEn | input | 1 | the byte in this write cycle is a command |
| addrEn | input | 1 | the byte in this write cycle is an address |
| wrStrobeN | input | 1 | write strobe; the byte is taken on its rising edge |
| rdStrobeN | input | 1 | read strobe; a falling edge steps the output |
| lockN | input | 1 | low blocks program and erase |
| busIn | input | 8 | byte from the host |
| busOut | output | 8 | byte to the host |
| busOe | output | 1 | output enable for `busOut` |
| ready | output | 1 | high when no operation is in progress |

## Verification
The bench builds the block with a 16-byte page, four array pages in blocks of two, and busy times of 4, 12 and 20 cycles. The array is then small enough to program, read back and erase in full. Column wrap, a block boundary and exact busy lengths all come up within a few hundred cycles. A program of 12 cycles is also long enough to issue status, ignored commands, a select drop or a reset while the operation is still running.

// File: rtl/nand_dev_pkg.sv
package nand_dev_pkg;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h60;
  localparam logic [7:0] OP_ERCONF  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  typedef enum logic [3:0] {
    M_IDLE, M_RDADDR, M_PGADDR, M_PGDATA, M_ERADDR, M_ERWAIT,
    M_RDBUSY, M_PGBUSY, M_ERBUSY
  } mode_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic       fill;     // preset page buffer to FFh
    logic       colLoad;  // load column pointer from bus
    logic       rowLoad;  // load one row byte from bus
    logic [1:0] rowSel;   // which row byte
    logic       dataWr;   // write bus byte at column, advance
    logic       readOut;  // read step
    logic       fetch;    // array page -> page buffer
    logic       store;    // page buffer -> array page
    logic       erase;    // clear addressed block
  } strobe_t;

endpackage

// File: rtl/nand_dev_ctl.sv
module nand_dev_ctl
  import nand_dev_pkg::*;
#(
  parameter int READ_BUSY  = 150,
  parameter int PROG_BUSY  = 2000,
  parameter int ERASE_BUSY = 20000,
  parameter int CNT_W      = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             cmdEn,
  input  logic             addrEn,
  input  logic             wrStrobeN,
  input  logic             rdStrobeN,
  input  logic             lockN,
  input  logic [7:0]       busIn,
  output strobe_t          stb,
  output logic             showStatus,
  output logic [7:0]       statusByte,
  output logic             ready,
  output logic [CNT_W-1:0] busyLeft
);

  mode_e            mode, nMode;
  logic [CNT_W-1:0] nLeft;
  logic [1:0]       addrCnt, nAddr;
  logic             fail, nFail, nShow;
  logic             wrQ, rdQ;
  logic             wrRise, rdFall, busy;

  assign wrRise = !selN && wrStrobeN && !wrQ;
  assign rdFall = !selN && !rdStrobeN && rdQ;
  assign busy   = (mode == M_RDBUSY) || (mode == M_PGBUSY) || (mode == M_ERBUSY);
  assign ready  = !busy;
  assign statusByte = {lockN, !busy, 5'b00000, fail};

  always_comb begin
    stb   = '0;
    nMode = mode;
    nLeft = busyLeft;
    nAddr = addrCnt;
    nFail = fail;
    nShow = showStatus;

    if (busy) begin
      if (busyLeft == '0) begin
        nMode = M_IDLE;
        case (mode)
          M_RDBUSY: stb.fetch = 1'b1;
          M_PGBUSY: if (lockN) stb.store = 1'b1; else nFail = 1'b1;
          default:  if (lockN) stb.erase = 1'b1; else nFail = 1'b1;
        endcase
      end else begin
        nLeft = busyLeft - 1'b1;
      end
    end

    if (wrRise && cmdEn && !addrEn) begin
      if (busIn == OP_RESET) begin
        nMode = M_IDLE; nLeft = '0; nFail = 1'b0; nShow = 1'b0;
        stb.fetch = 1'b0; stb.store = 1'b0; stb.erase = 1'b0;
      end else if (busIn == OP_STATUS) begin
        nShow = 1'b1;
      end else if (!busy) begin
        case (busIn)
          OP_READ:  begin nMode = M_RDADDR; nAddr = '0; nShow = 1'b0; end
          OP_LOAD:  begin nMode = M_PGADDR; nAddr = '0; nShow = 1'b0; stb.fill = 1'b1; end
          OP_ERASE: begin nMode = M_ERADDR; nAddr = '0; nShow = 1'b0; end
          OP_PROG: if (mode == M_PGDATA) begin
            if (lockN) begin nMode = M_PGBUSY; nLeft = CNT_W'(PROG_BUSY - 1); nFail = 1'b0; end
            else       begin nMode = M_IDLE; nFail = 1'b1; end
          end
          OP_ERCONF: if (mode == M_ERWAIT) begin
            if (lockN) begin nMode = M_ERBUSY; nLeft = CNT_W'(ERASE_BUSY - 1); nFail = 1'b0; end
            else       begin nMode = M_IDLE; nFail = 1'b1; end
          end
          default: ;
        endcase
      end
    end else if (wrRise && addrEn && !cmdEn && !busy) begin
      if (mode == M_RDADDR || mode == M_PGADDR) begin
        if (addrCnt == 2'd0) stb.colLoad = 1'b1;
        else begin stb.rowLoad = 1'b1; stb.rowSel = addrCnt - 2'd1; end
        nAddr = addrCnt + 2'd1;
        if (addrCnt == 2'd3) begin
          if (mode == M_RDADDR) begin nMode = M_RDBUSY; nLeft = CNT_W'(READ_BUSY - 1); end
          else nMode = M_PGDATA;
        end
      end else if (mode == M_ERADDR) begin
        stb.rowLoad = 1'b1;
        stb.rowSel  = addrCnt;
        nAddr = addrCnt + 2'd1;
        if (addrCnt == 2'd2) nMode = M_ERWAIT;
      end
    end else if (wrRise && !addrEn && !cmdEn && mode == M_PGDATA) begin
      stb.dataWr = 1'b1;
    end

    if (rdFall) stb.readOut = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= M_IDLE;
      busyLeft   <= '0;
      addrCnt    <= '0;
      fail       <= 1'b0;
      showStatus <= 1'b0;
      wrQ        <= 1'b1;
      rdQ        <= 1'b1;
    end else begin
      mode       <= nMode;
      busyLeft   <= nLeft;
      addrCnt    <= nAddr;
      fail       <= nFail;
      showStatus <= nShow;
      wrQ        <= wrStrobeN;
      rdQ        <= rdStrobeN;
    end
  end

endmodule

// File: rtl/nand_dev_dp.sv
module nand_dev_dp
  import nand_dev_pkg::*;
#(
  parameter int PAGE_BYTES      = 528,
  parameter int ARRAY_PAGES     = 4,
  parameter int PAGES_PER_BLOCK = 32,
  localparam int COL_W   = $clog2(PAGE_BYTES),
  localparam int IDX_W   = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1,
  localparam int BLK_SH  = $clog2(PAGES_PER_BLOCK),
  localparam int MEM_B   = ARRAY_PAGES * PAGE_BYTES,
  localparam int MEM_AW  = $clog2(MEM_B)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       busIn,
  input  logic             showStatus,
  input  logic [7:0]       statusByte,
  output logic [7:0]       outByte
);

  logic [7:0]        pageReg [PAGE_BYTES];
  logic [7:0]        mem     [MEM_B];
  logic [COL_W-1:0]  col, colNext;
  logic [23:0]       row;
  logic [IDX_W-1:0]  rowIdx;
  logic [MEM_AW-1:0] rowBase;

  assign rowIdx  = row[IDX_W-1:0];
  assign rowBase = MEM_AW'(rowIdx) * MEM_AW'(PAGE_BYTES);
  assign colNext = (col == COL_W'(PAGE_BYTES - 1)) ? '0 : col + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      col     <= '0;
      row     <= '0;
      outByte <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      for (int j = 0; j < MEM_B; j++)      mem[j]     <= 8'hFF;
    end else begin
      if (stb.fill)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      else if (stb.fetch)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= mem[rowBase + MEM_AW'(i)];
      else if (stb.dataWr)
        pageReg[col] <= busIn;

      if (stb.colLoad)
        col <= COL_W'(busIn);
      else if (stb.dataWr || (stb.readOut && !showStatus))
        col <= colNext;

      if (stb.rowLoad) row[{stb.rowSel, 3'b000} +: 8] <= busIn;

      if (stb.readOut) outByte <= showStatus ? statusByte : pageReg[col];

      if (stb.store)
        for (int i = 0; i < PAGE_BYTES; i++) mem[rowBase + MEM_AW'(i)] <= pageReg[i];

      if (stb.erase)
        for (int p = 0; p < ARRAY_PAGES; p++)
          if ((p >> BLK_SH) == (int'(rowIdx) >> BLK_SH))
            for (int i = 0; i < PAGE_BYTES; i++) mem[MEM_AW'(p * PAGE_BYTES + i)] <= 8'hFF;
    end
  end

endmodule

// File: rtl/nand_dev_top.sv
module nand_dev_top
  import nand_dev_pkg::*;
#(
  parameter int PAGE_BYTES      = 528,
  parameter int ARRAY_PAGES     = 4,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int READ_BUSY       = 150,
  parameter int PROG_BUSY       = 2000,
  parameter int ERASE_BUSY      = 20000,
  localparam int MAX_A = (READ_BUSY > PROG_BUSY) ? READ_BUSY : PROG_BUSY,
  localparam int MAX_B = (MAX_A > ERASE_BUSY) ? MAX_A : ERASE_BUSY,
  localparam int CNT_W = $clog2(MAX_B + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       cmdEn,
  input  logic       addrEn,
  input  logic       wrStrobeN,
  input  logic       rdStrobeN,
  input  logic       lockN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busOe,
  output logic       ready
);

  strobe_t          stb;
  logic             showStatus;
  logic [7:0]       statusByte, outByte;
  logic [CNT_W-1:0] busyLeft;

  nand_dev_ctl #(
    .READ_BUSY(READ_BUSY), .PROG_BUSY(PROG_BUSY),
    .ERASE_BUSY(ERASE_BUSY), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .selN(selN), .cmdEn(cmdEn), .addrEn(addrEn),
    .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN), .lockN(lockN), .busIn(busIn),
    .stb(stb), .showStatus(showStatus), .statusByte(statusByte),
    .ready(ready), .busyLeft(busyLeft)
  );

  nand_dev_dp #(
    .PAGE_BYTES(PAGE_BYTES), .ARRAY_PAGES(ARRAY_PAGES),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busIn(busIn),
    .showStatus(showStatus), .statusByte(statusByte), .outByte(outByte)
  );

  assign busOe  = !selN && !rdStrobeN;
  assign busOut = busOe ? outByte : 8'h00;

endmodule

// File: rtl/nand_dev_chk.sv
module nand_dev_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             selN,
  input logic             cmdEn,
  input logic             addrEn,
  input logic             wrStrobeN,
  input logic             rdStrobeN,
  input logic [7:0]       busIn,
  input logic [7:0]       busOut,
  input logic             busOe,
  input logic             ready,
  input logic [CNT_W-1:0] busyLeft
);

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selN || rdStrobeN) |-> (!busOe && busOut == 8'h00));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> ($past(wrStrobeN) && !$past(wrStrobeN, 2)));

  // R11
  select_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && selN && busyLeft != '0) |=> !ready);

  // R12
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && cmdEn && !addrEn && wrStrobeN && !$past(wrStrobeN) && busIn == 8'hFF)
      |=> ready);

endmodule

bind nand_dev_top nand_dev_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .cmdEn(cmdEn), .addrEn(addrEn),
  .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN), .busIn(busIn),
  .busOut(busOut), .busOe(busOe), .ready(ready), .busyLeft(busyLeft)
);

// File: tb/sim_nand_dev_top.sv
module sim_nand_dev_top;

  localparam int PB  = 16;
  localparam int AP  = 4;
  localparam int PPB = 2;
  localparam int RB  = 4;
  localparam int PGB = 12;
  localparam int EB  = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, selN, cmdEn, addrEn, wrStrobeN, rdStrobeN, lockN;
  logic [7:0] busIn, busOut;
  logic busOe, ready;

  nand_dev_top #(
    .PAGE_BYTES(PB), .ARRAY_PAGES(AP), .PAGES_PER_BLOCK(PPB),
    .READ_BUSY(RB), .PROG_BUSY(PGB), .ERASE_BUSY(EB)
  ) u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .cmdEn(cmdEn), .addrEn(addrEn),
    .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN), .lockN(lockN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .ready(ready)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;
  logic [7:0] model [AP][PB];

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d, input logic ce = 1'b0);
    @(negedge clk); selN = ce; cmdEn = c; addrEn = a; busIn = d; wrStrobeN = 1'b0;
    @(negedge clk); wrStrobeN = 1'b1;
    @(negedge clk); cmdEn = 1'b0; addrEn = 1'b0; selN = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); rdStrobeN = 1'b0;
    @(negedge clk); b = busOut; rdStrobeN = 1'b1;
  endtask

  task automatic waitRdy(output int n);
    n = 0;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic addr4(input logic [7:0] col, input logic [7:0] pg);
    wr(0, 1, col); wr(0, 1, pg); wr(0, 1, 8'h00); wr(0, 1, 8'h00);
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic readPage(input int p, input int col, input int cnt, input string req);
    int n; logic [7:0] b;
    wr(1, 0, 8'h00); addr4(8'(col), 8'(p));
    waitRdy(n);
    chk("R6 read busy", n, RB);
    for (int k = 0; k < cnt; k++) begin
      rd(b);
      chk(req, b, model[p][(col + k) % PB]);
    end
  endtask

  task automatic statusIs(input int exp, input string req);
    logic [7:0] b;
    wr(1, 0, 8'h70); rd(b);
    chk(req, b, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int n; logic [7:0] b;
    rstN = 0; selN = 1; cmdEn = 0; addrEn = 0; wrStrobeN = 1; rdStrobeN = 1;
    lockN = 1; busIn = 0;
    for (int p = 0; p < AP; p++) for (int i = 0; i < PB; i++) model[p][i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R6 ready in reset", ready, 1);
    rstN = 1; selN = 0;
    @(negedge clk);
    chk("R5 oe idle", busOe, 0);

    // R2 fresh array reads back erased
    readPage(0, 0, PB, "R2 fresh read");

    // R7 program every page, then read all back
    for (int p = 0; p < AP; p++) begin
      wr(1, 0, 8'h80); addr4(8'h00, 8'(p));
      for (int i = 0; i < PB; i++) wr(0, 0, pat(p, i));
      wr(1, 0, 8'h10);
      waitRdy(n);
      chk("R6 program busy", n, PGB);
      for (int i = 0; i < PB; i++) model[p][i] = pat(p, i);
    end
    for (int p = 0; p < AP; p++) readPage(p, 0, PB, "R7 page content");

    // R4 start mid-page and wrap past the last byte
    readPage(1, 13, 5, "R4 column wrap");

    // R5 no drive while deselected or read strobe high
    @(negedge clk); selN = 1; rdStrobeN = 0;
    @(negedge clk);
    chk("R5 oe deselected", busOe, 0);
    chk("R5 out deselected", busOut, 0);
    rdStrobeN = 1; selN = 0;
    @(negedge clk);
    chk("R5 oe strobe high", busOe, 0);

    // R3 partial load with FF preset; R1 deselected data cycle ignored
    wr(1, 0, 8'h80); addr4(8'h04, 8'h01);
    wr(0, 0, 8'hAA); wr(0, 0, 8'hBB); wr(0, 0, 8'hCC, 1'b1); wr(0, 0, 8'hDD);
    wr(1, 0, 8'h10); waitRdy(n);
    for (int i = 0; i < PB; i++) model[1][i] = 8'hFF;
    model[1][4] = 8'hAA; model[1][5] = 8'hBB; model[1][6] = 8'hDD;
    readPage(1, 0, PB, "R3 R1 partial load");

    // R10 status idle
    statusIs(8'hC0, "R10 status idle");

    // R9 locked program and erase
    lockN = 0;
    wr(1, 0, 8'h80); addr4(8'h00, 8'h00);
    wr(0, 0, 8'h12); wr(0, 0, 8'h34); wr(1, 0, 8'h10);
    chk("R9 no busy locked program", ready, 1);
    statusIs(8'h41, "R9 R10 locked status");
    wr(1, 0, 8'h60); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(1, 0, 8'hD0);
    chk("R9 no busy locked erase", ready, 1);
    lockN = 1;
    readPage(0, 0, PB, "R9 page kept");

    // R9 lock asserted during program busy
    wr(1, 0, 8'h80); addr4(8'h00, 8'h03);
    for (int i = 0; i < PB; i++) wr(0, 0, 8'(i));
    wr(1, 0, 8'h10);
    @(negedge clk); lockN = 0;
    waitRdy(n);
    lockN = 1;
    statusIs(8'hC1, "R9 late lock fail bit");
    readPage(3, 0, PB, "R9 late lock page kept");

    // R13 commands ignored while busy, status visible while busy
    wr(1, 0, 8'h80); addr4(8'h00, 8'h02);
    for (int i = 0; i < PB; i++) wr(0, 0, pat(9, i));
    wr(1, 0, 8'h10);
    wr(1, 0, 8'h70); wr(1, 0, 8'h00); wr(0, 1, 8'h05);
    rd(b);
    chk("R13 R10 busy status", b, 8'h80);
    waitRdy(n);
    for (int i = 0; i < PB; i++) model[2][i] = pat(9, i);
    readPage(2, 0, PB, "R13 program completed");

    // R11 deselect during busy
    wr(1, 0, 8'h80); addr4(8'h00, 8'h00);
    for (int i = 0; i < PB; i++) wr(0, 0, pat(5, i));
    wr(1, 0, 8'h10);
    selN = 1;
    waitRdy(n);
    selN = 0;
    chk("R11 busy length deselected", n, PGB);
    for (int i = 0; i < PB; i++) model[0][i] = pat(5, i);
    readPage(0, 0, PB, "R11 program kept");

    // R8 erase block of pages 2 and 3
    wr(1, 0, 8'h60); wr(0, 1, 8'h02); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(1, 0, 8'hD0);
    waitRdy(n);
    chk("R8 R6 erase busy", n, EB);
    for (int p = 2; p < AP; p++) for (int i = 0; i < PB; i++) model[p][i] = 8'hFF;
    for (int p = 0; p < AP; p++) readPage(p, 0, PB, "R8 erase block");

    // R12 reset aborts an erase
    wr(1, 0, 8'h60); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(1, 0, 8'hD0);
    chk("R12 erase started", ready, 0);
    @(negedge clk); @(negedge clk);
    wr(1, 0, 8'hFF);
    chk("R12 ready after reset cmd", ready, 1);
    statusIs(8'hC0, "R12 status cleared");
    readPage(0, 0, PB, "R12 page 0 kept");
    readPage(1, 0, PB, "R12 page 1 kept");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule